// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block generates the digital frequency-offset word that a current-steering DAC uses to pull a PLL oscillator. It runs on the reference clock. Three static mode inputs select its behaviour: modulation on or off, a centred or a downward-biased spread, and a small or a large level. With modulation on, the word sweeps a symmetric triangle between two bounds. With modulation off, it holds a fixed value. The word is signed and counts in hundredths of a percent of the nominal frequency.

A single triangle engine serves every mode; only its bounds, its centre and its slope change. Any change on a mode input throws the sweep back to the centre of the newly chosen range at the next reference edge. The same happens on reset and on the power-down hold, so the word never walks through stray values when the configuration moves. The word comes straight from one register, so all of its bits change together.

Top module: `ssc_profile_gen`

## Requirements
- R1: With modulation on and centre type selected (centreSel=1), the word sweeps between -PEAK and +PEAK: ±50 (±0.50%) when levelSel=0 and ±100 (±1.00%) when levelSel=1. The word is two's complement, CODE_W=12 bits wide, in units of 0.01%.
- R2: With modulation on and down type selected (centreSel=0), the word sweeps between 0 and -2*PEAK: 0 to -100 when levelSel=0 and 0 to -200 when levelSel=1.
- R3: With modulation off and centre type selected, the word is held at 0 whatever levelSel is.
- R4: With modulation off and down type selected, the word is held at -PEAK: -50 when levelSel=0 and -100 when levelSel=1. This is the middle of the matching down-spread range.
- R5: The word moves once every STEP_DIV reference cycles (19 by default). Each move is 2*PEAK/HALF_STEPS (5 or 10 at the defaults). The first move comes STEP_DIV cycles after the last restart edge. One full sweep therefore takes 2*HALF_STEPS*STEP_DIV cycles, which is 760 cycles, or about 31.6 kHz at 24 MHz.
- R6: After a restart the sweep first moves upward. It turns round exactly on the upper and lower bounds and never passes them.
- R7: When any of modEn, centreSel or levelSel changes, the next reference edge loads the centre of the new range (0 for centre type, -PEAK for down type) and restarts the step timer.
- R8: While rstN is low or holdReq is high, every edge loads the fixed non-spread value for the current type and level. After release, the first move comes STEP_DIV cycles after the last held edge.
- R9: The word changes only at a timed step or at a restart. A step moves it by exactly one slope or onto a bound, so the DAC sees no intermediate code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Synchronous reset, active low |
| holdReq | input | 1 | Power-down hold; parks the word at the non-spread value |
| modEn | input | 1 | 1 = triangle modulation, 0 = fixed offset |
| centreSel | input | 1 | 1 = centre-referenced range, 0 = downward-biased range |
| levelSel | input | 1 | 0 = small peak (PEAK_LO), 1 = large peak (PEAK_HI) |
| offsetCode | output | CODE_W | Signed frequency offset in 0.01% units |

## Verification
On every cycle the embedded assertions check the local mechanics of the sweep:
- a restart loads the decoded centre;
- the word is stable between steps;
- a step is one slope or a landing on a bound;
- a step taken at the top bound turns the sweep downward;
- the word stays inside the latched bounds;
- steps are spaced apart;
- no step is issued with modulation off.

Only the bench scenarios can show the absolute values: the peak and trough reached for each type and level, the parked value for each mode, the length of a full sweep, and the centre value loaded after a change in mid-sweep. Those scenarios compare the word against an independent cycle model on every clock.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  parameter int CODE_W = 12;

  typedef logic signed [CODE_W-1:0] code_t;
  typedef logic signed [CODE_W:0]   wide_t;

  typedef struct packed {
    logic modEn;
    logic centreType;
    logic levelHi;
  } mode_t;

  typedef struct packed {
    logic restart;
    logic step;
  } strobe_t;

  typedef struct packed {
    code_t lo;
    code_t hi;
    code_t mid;
    code_t slope;
  } range_t;

endpackage

// File: rtl/ssc_ctrl.sv
module ssc_ctrl
  import ssc_pkg::*;
#(
  parameter int PEAK_LO    = 50,
  parameter int PEAK_HI    = 100,
  parameter int HALF_STEPS = 20,
  parameter int STEP_DIV   = 19
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    holdReq,
  input  mode_t   modeIn,
  output strobe_t strb,
  output range_t  rng
);

  localparam int SLOPE_LO = (2 * PEAK_LO) / HALF_STEPS;
  localparam int SLOPE_HI = (2 * PEAK_HI) / HALF_STEPS;
  localparam int CNT_W    = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;

  mode_t modeQ;
  logic  modeMoved;
  logic  tick;
  code_t peak;

  // remember the mode seen at the previous edge
  always_ff @(posedge clk) begin
    modeQ <= modeIn;
  end

  assign modeMoved = (modeIn != modeQ);

  // range decode from the live mode inputs
  always_comb begin
    peak      = modeIn.levelHi ? code_t'(PEAK_HI) : code_t'(PEAK_LO);
    rng.slope = modeIn.levelHi ? code_t'(SLOPE_HI) : code_t'(SLOPE_LO);
    if (modeIn.centreType) begin
      rng.lo  = -peak;
      rng.hi  = peak;
      rng.mid = '0;
    end else begin
      rng.lo  = -(peak + peak);
      rng.hi  = '0;
      rng.mid = -peak;
    end
  end

  // step timer
  generate
    if (STEP_DIV > 1) begin : g_div
      logic [CNT_W-1:0] divQ;
      always_ff @(posedge clk) begin
        if (strb.restart)                       divQ <= '0;
        else if (divQ == CNT_W'(STEP_DIV - 1))  divQ <= '0;
        else                                    divQ <= divQ + CNT_W'(1);
      end
      assign tick = (divQ == CNT_W'(STEP_DIV - 1));

      AST_STEP_SPACING: assert property (@(posedge clk) disable iff (!rstN)
        strb.step |=> !strb.step); // R5
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  always_comb begin
    strb.restart = !rstN || holdReq || modeMoved;
    strb.step    = tick && !strb.restart && modeIn.modEn;
  end

  AST_NO_STEP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !modeIn.modEn |-> !strb.step); // R3

  AST_HOLD_FORCES_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    holdReq |-> !strb.step); // R8

endmodule

// File: rtl/ssc_datapath.sv
module ssc_datapath
  import ssc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strb,
  input  range_t  rng,
  output code_t   codeQ
);

  logic  dirUp;
  code_t bndLo;
  code_t bndHi;
  code_t slopeQ;
  code_t nextCode;
  logic  nextDir;
  wide_t upSum;
  wide_t dnSum;

  assign upSum = wide_t'(codeQ) + wide_t'(slopeQ);
  assign dnSum = wide_t'(codeQ) - wide_t'(slopeQ);

  // next point on the triangle, clamped to the bounds with reversal
  always_comb begin
    nextCode = codeQ;
    nextDir  = dirUp;
    if (dirUp) begin
      if (upSum >= wide_t'(bndHi)) begin
        nextCode = bndHi;
        nextDir  = 1'b0;
      end else begin
        nextCode = code_t'(upSum);
      end
    end else begin
      if (dnSum <= wide_t'(bndLo)) begin
        nextCode = bndLo;
        nextDir  = 1'b1;
      end else begin
        nextCode = code_t'(dnSum);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.restart) begin
      codeQ  <= rng.mid;
      dirUp  <= 1'b1;
      bndLo  <= rng.lo;
      bndHi  <= rng.hi;
      slopeQ <= rng.slope;
    end else if (strb.step) begin
      codeQ  <= nextCode;
      dirUp  <= nextDir;
    end
  end

  AST_RESTART_LOADS_MID: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |=> (codeQ == $past(rng.mid))); // R7

  AST_STILL_BETWEEN_STEPS: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.restart && !strb.step) |=> $stable(codeQ)); // R9

  AST_ONE_SLOPE_PER_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.restart) |=>
      ((codeQ == $past(codeQ) + $past(slopeQ)) ||
       (codeQ == $past(codeQ) - $past(slopeQ)) ||
       (codeQ == $past(bndHi)) || (codeQ == $past(bndLo)))); // R9

  AST_CODE_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    (codeQ >= bndLo) && (codeQ <= bndHi)); // R6

  AST_TURN_AT_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.restart && codeQ == bndHi) |=> (codeQ < $past(codeQ))); // R6

endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
  import ssc_pkg::*;
#(
  parameter int PEAK_LO    = 50,
  parameter int PEAK_HI    = 100,
  parameter int HALF_STEPS = 20,
  parameter int STEP_DIV   = 19
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     holdReq,
  input  logic                     modEn,
  input  logic                     centreSel,
  input  logic                     levelSel,
  output logic signed [CODE_W-1:0] offsetCode
);

  mode_t   modeIn;
  strobe_t strb;
  range_t  rng;
  code_t   codeQ;

  assign modeIn.modEn      = modEn;
  assign modeIn.centreType = centreSel;
  assign modeIn.levelHi    = levelSel;

  ssc_ctrl #(
    .PEAK_LO    (PEAK_LO),
    .PEAK_HI    (PEAK_HI),
    .HALF_STEPS (HALF_STEPS),
    .STEP_DIV   (STEP_DIV)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .holdReq (holdReq),
    .modeIn  (modeIn),
    .strb    (strb),
    .rng     (rng)
  );

  ssc_datapath dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .rng   (rng),
    .codeQ (codeQ)
  );

  assign offsetCode = codeQ;

endmodule

// File: tb/ssc_profile_gen_tb.sv
module ssc_profile_gen_tb_top;
  import ssc_pkg::*;

  localparam int PK_LO = 50;
  localparam int PK_HI = 100;
  localparam int HALF  = 20;
  localparam int DIV   = 19;
  localparam int PERIOD_CYC = 2 * HALF * DIV;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic holdReq = 1'b0;
  logic modEn = 1'b0;
  logic centreSel = 1'b1;
  logic levelSel = 1'b0;
  logic signed [CODE_W-1:0] offsetCode;

  int nCmp = 0;
  int nBad = 0;
  int cyc = 0;
  string reqTag = "R8";
  bit started = 0;
  bit winClr = 0;
  int winMin, winMax;

  // reference model state
  logic [2:0] mPrev = 3'bxxx;
  int mCode = 0, mCnt = 0, mLo = 0, mHi = 0, mSl = 0;
  bit mUp = 1;
  int pk, lo, hi, mid, sl;

  always #4 clk = ~clk;  // 125 MHz

  ssc_profile_gen dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .holdReq    (holdReq),
    .modEn      (modEn),
    .centreSel  (centreSel),
    .levelSel   (levelSel),
    .offsetCode (offsetCode)
  );

  task automatic check(input string tag, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: offsetCode actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference, advanced on each reference edge
  always @(posedge clk) begin
    cyc++;
    started = 1;
    pk  = levelSel ? PK_HI : PK_LO;
    sl  = (2 * pk) / HALF;
    lo  = centreSel ? -pk : -2 * pk;
    hi  = centreSel ? pk : 0;
    mid = centreSel ? 0 : -pk;
    if (!rstN || holdReq || ({modEn, centreSel, levelSel} !== mPrev)) begin
      mCode = mid; mCnt = 0; mUp = 1; mLo = lo; mHi = hi; mSl = sl;
    end else if (mCnt == DIV - 1) begin
      mCnt = 0;
      if (modEn) begin
        if (mUp) begin
          if (mCode + mSl >= mHi) begin mCode = mHi; mUp = 0; end
          else mCode = mCode + mSl;
        end else begin
          if (mCode - mSl <= mLo) begin mCode = mLo; mUp = 1; end
          else mCode = mCode - mSl;
        end
      end
    end else begin
      mCnt++;
    end
    mPrev = {modEn, centreSel, levelSel};
    if (cyc > 150000) begin
      nBad++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  // every-cycle comparison and window tracking
  always @(negedge clk) begin
    if (started) begin
      check(reqTag, int'(offsetCode), mCode);
      if (winClr) begin
        winMin = int'(offsetCode); winMax = int'(offsetCode); winClr = 0;
      end else begin
        if (int'(offsetCode) < winMin) winMin = int'(offsetCode);
        if (int'(offsetCode) > winMax) winMax = int'(offsetCode);
      end
    end
  end

  task automatic setMode(input logic en, input logic ctr, input logic lvl, input string tag);
    @(negedge clk);
    modEn = en; centreSel = ctr; levelSel = lvl; reqTag = tag;
    @(posedge clk);     // restart edge
    #1 winClr = 1;
  endtask

  task automatic sweepCheck(input string tag, input int expMax, input int expMin);
    repeat (PERIOD_CYC + 2) @(posedge clk);
    @(negedge clk);
    check({tag, " max"}, winMax, expMax);
    check({tag, " min"}, winMin, expMin);
  endtask

  initial begin
    // R8: reset parks the word for the current type
    repeat (4) @(negedge clk);
    check("R8 reset centre", int'(offsetCode), 0);
    centreSel = 1'b0; levelSel = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 reset down", int'(offsetCode), -100);
    centreSel = 1'b1; levelSel = 1'b0; modEn = 1'b1; reqTag = "R5";
    repeat (2) @(negedge clk);
    rstN = 1'b1;

    // R5: first move timing and step size, R6 turn at peak
    @(posedge clk); #1 winClr = 1;
    @(negedge clk);
    check("R5 start", int'(offsetCode), 0);
    repeat (DIV - 2) @(posedge clk);
    @(negedge clk);
    check("R5 before first step", int'(offsetCode), 0);
    @(posedge clk); @(negedge clk);
    check("R5 first step", int'(offsetCode), 5);
    repeat (9 * DIV) @(posedge clk);
    @(negedge clk);
    check("R6 top reached", int'(offsetCode), 50);
    repeat (DIV) @(posedge clk);
    @(negedge clk);
    check("R6 turned down", int'(offsetCode), 45);
    repeat (PERIOD_CYC - 11 * DIV) @(posedge clk);
    @(negedge clk);
    check("R5 full period", int'(offsetCode), 0);

    // R1 centre spread both levels
    setMode(1, 1, 0, "R1"); sweepCheck("R1 lo", 50, -50);
    setMode(1, 1, 1, "R1"); sweepCheck("R1 hi", 100, -100);
    // R2 down spread both levels
    setMode(1, 0, 0, "R2"); sweepCheck("R2 lo", 0, -100);
    setMode(1, 0, 1, "R6"); sweepCheck("R2 hi", 0, -200);
    // R3 non-spread centre
    setMode(0, 1, 0, "R3"); sweepCheck("R3 lo", 0, 0);
    setMode(0, 1, 1, "R3"); sweepCheck("R3 hi", 0, 0);
    // R4 non-spread down
    setMode(0, 0, 0, "R4"); sweepCheck("R4 lo", -50, -50);
    setMode(0, 0, 1, "R4"); sweepCheck("R4 hi", -100, -100);

    // R7 change in mid-sweep
    setMode(1, 1, 1, "R9");
    repeat (300) @(posedge clk);
    @(negedge clk);
    centreSel = 1'b0; levelSel = 1'b0; reqTag = "R7";
    @(posedge clk); @(negedge clk);
    check("R7 new centre", int'(offsetCode), -50);
    repeat (DIV - 1) @(posedge clk);
    @(negedge clk);
    check("R7 timer restarted", int'(offsetCode), -50);
    @(posedge clk); @(negedge clk);
    check("R7 first step", int'(offsetCode), -45);

    // R8 power-down hold
    repeat (200) @(posedge clk);
    @(negedge clk);
    holdReq = 1'b1; levelSel = 1'b1; reqTag = "R8";
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 hold park", int'(offsetCode), -100);
    holdReq = 1'b0;
    repeat (DIV - 1) @(posedge clk);
    @(negedge clk);
    check("R8 still parked", int'(offsetCode), -100);
    @(posedge clk); @(negedge clk);
    check("R8 first step after hold", int'(offsetCode), -90);
    repeat (100) @(posedge clk);
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule